// File: doc/BRIEF.md
# Memory-Based Interrupt Report Writer

This block reports interrupts by writing to memory instead of holding them in status registers. Each source unit raises events on its own 16-bit event vector. The block accumulates those events per unit. When any are pending it starts a report pass. A pass first reads a 16-bit enable mask from the report region. It then takes a masked snapshot of every unit's pending vector. For each enabled event bit it writes one whole byte of 0xFF into that unit's status slot. After a unit's status bytes it writes 0xFF into that unit's byte in the source area. When every write of the pass has been accepted, it pulses the host interrupt line.

The region base is a parameter aligned to 4 KiB. The status area starts at offset 0x000, with 16 bytes per unit at base + unit*16 + bit. The source area starts at offset 0x400, with one byte per unit at base + 0x400 + unit. The mask word sits at offset 0x440. Memory writes leave through a byte-write port with a valid/ready handshake. The mask arrives on a request/valid read port. A host that clears the bytes it consumed can walk the source bytes and then the status slots to find every event.

Top module: `mbi_report_writer`

## Requirements
- R1: For every unit u and bit b that is set in the pass snapshot and enabled in the mask, exactly one byte of value 0xFF is written at BASE_ADDR + u*16 + b.
- R2: For every unit whose masked snapshot is non-zero, one byte of value 0xFF is written at BASE_ADDR + 0x400 + u, after all of that unit's status bytes.
- R3: Within a pass, units are served in ascending index order. Within a unit, status bytes go in ascending bit order, followed by the unit's source byte. No other writes occur.
- R4: Each pass begins with exactly one mask read at BASE_ADDR + 0x440, and no write overlaps it. Bit b of the returned mask enables bit b of every unit. The mask is fetched again for every pass, so a new mask value takes effect on the next pass.
- R5: Masked-off bits produce no status byte. A unit whose masked vector is zero gets no source byte. A pass with no enabled bit writes nothing and raises no interrupt. Snapshotted bits that are masked off are discarded and are not reported in later passes.
- R6: host_irq_o is a single-cycle pulse, one per pass that wrote anything. It is raised only after the last write of that pass has been accepted, and never together with a write or a read request.
- R7: Events that arrive while a pass is in progress are OR-accumulated per unit and reported in a following pass, so none are lost.
- R8: While wr_valid_o is high and wr_ready_i is low, wr_valid_o stays high and wr_addr_o stays stable.
- R9: After reset, wr_valid_o, rd_req_o and host_irq_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_i | input | NUM_UNITS*16 | Event vectors; unit u occupies bits [u*16 +: 16]; a set bit is one event |
| wr_valid_o | output | 1 | Byte write request |
| wr_ready_i | input | 1 | Write accepted this cycle when high with wr_valid_o |
| wr_addr_o | output | ADDR_W | Byte write address |
| wr_data_o | output | 8 | Byte write data, always the marker 0xFF |
| rd_req_o | output | 1 | Mask read request, held until rd_valid_i |
| rd_addr_o | output | ADDR_W | Mask read address |
| rd_valid_i | input | 1 | Mask read data valid |
| rd_data_i | input | 16 | Enable mask returned by the read |
| host_irq_o | output | 1 | One-cycle interrupt pulse to the host |

## Verification
A corrupted snapshot or a stuck bit counter appears at the write port within the same pass. It shows up as a missing byte, a duplicated byte or an out-of-order address before that pass's interrupt pulse. If the pending accumulator loses an event, a whole expected pass fails to occur. The interrupt count and the per-pass read count then fall short within a few hundred cycles. A mask register that is not refreshed shows as status bytes for disabled bits on the very next pass.

// File: rtl/mbi_pkg.sv
package mbi_pkg;
  localparam int VEC_W       = 16;
  localparam int STAT_STRIDE = 16;
  localparam int SRC_OFS     = 'h400;
  localparam int MASK_OFS    = 'h440;
  localparam int MAX_UNITS   = 64;
  localparam logic [7:0] MARK = 8'hFF;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_UNIT,
    ST_BIT,
    ST_SRC,
    ST_IRQ
  } seq_state_e;
endpackage

// File: rtl/mbi_pending.sv
module mbi_pending
  import mbi_pkg::*;
#(
  parameter int NUM_UNITS = 6
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [NUM_UNITS*VEC_W-1:0] evt_i,
  input  logic                       take_i,
  input  logic [VEC_W-1:0]           mask_i,
  output logic [NUM_UNITS*VEC_W-1:0] snap_o,
  output logic                       pend_any_o
);
  logic [NUM_UNITS*VEC_W-1:0] pend_q;

  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        pend_q[u*VEC_W +: VEC_W] <= '0;
        snap_o[u*VEC_W +: VEC_W] <= '0;
      end else if (take_i) begin
        // masked-off bits are dropped here; new arrivals start the next set
        snap_o[u*VEC_W +: VEC_W] <= pend_q[u*VEC_W +: VEC_W] & mask_i;
        pend_q[u*VEC_W +: VEC_W] <= evt_i[u*VEC_W +: VEC_W];
      end else begin
        pend_q[u*VEC_W +: VEC_W] <= pend_q[u*VEC_W +: VEC_W] | evt_i[u*VEC_W +: VEC_W];
      end
    end
  end

  assign pend_any_o = |pend_q;
endmodule

// File: rtl/mbi_addr_gen.sv
module mbi_addr_gen
  import mbi_pkg::*;
#(
  parameter int                NUM_UNITS = 6,
  parameter int                ADDR_W    = 32,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 'h1000,
  localparam int               UNIT_W    = (NUM_UNITS > 1) ? $clog2(NUM_UNITS) : 1,
  localparam int               BIT_W     = $clog2(VEC_W)
) (
  input  logic [UNIT_W-1:0] unit_i,
  input  logic [BIT_W-1:0]  bit_i,
  input  logic              sel_src_i,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [ADDR_W-1:0] rd_addr_o
);
  logic [ADDR_W-1:0] stat_addr;
  logic [ADDR_W-1:0] src_addr;

  assign stat_addr = BASE_ADDR + ADDR_W'(unit_i) * ADDR_W'(STAT_STRIDE) + ADDR_W'(bit_i);
  assign src_addr  = BASE_ADDR + ADDR_W'(SRC_OFS) + ADDR_W'(unit_i);
  assign wr_addr_o = sel_src_i ? src_addr : stat_addr;
  assign rd_addr_o = BASE_ADDR + ADDR_W'(MASK_OFS);
endmodule

// File: rtl/mbi_seq.sv
module mbi_seq
  import mbi_pkg::*;
#(
  parameter int  NUM_UNITS = 6,
  localparam int UNIT_W    = (NUM_UNITS > 1) ? $clog2(NUM_UNITS) : 1,
  localparam int BIT_W     = $clog2(VEC_W)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       pend_any_i,
  input  logic [NUM_UNITS*VEC_W-1:0] snap_i,
  input  logic                       rd_valid_i,
  input  logic                       wr_ready_i,
  output logic                       take_o,
  output logic                       rd_req_o,
  output logic                       wr_valid_o,
  output logic                       sel_src_o,
  output logic [UNIT_W-1:0]          unit_o,
  output logic [BIT_W-1:0]           bit_o,
  output logic                       host_irq_o
);
  seq_state_e        state_q;
  logic [UNIT_W-1:0] unit_q;
  logic [BIT_W-1:0]  bit_q;
  logic [VEC_W-1:0]  cur_vec;
  logic              last_unit;
  logic              last_bit;
  logic              any_snap;

  assign cur_vec   = snap_i[int'(unit_q)*VEC_W +: VEC_W];
  assign last_unit = (unit_q == UNIT_W'(NUM_UNITS - 1));
  assign last_bit  = (bit_q == BIT_W'(VEC_W - 1));
  assign any_snap  = |snap_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      unit_q  <= '0;
      bit_q   <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (pend_any_i) state_q <= ST_FETCH;
        ST_FETCH: begin
          if (rd_valid_i) begin
            unit_q  <= '0;
            state_q <= ST_UNIT;
          end
        end
        ST_UNIT: begin
          if (cur_vec != '0) begin
            bit_q   <= '0;
            state_q <= ST_BIT;
          end else if (last_unit) begin
            state_q <= any_snap ? ST_IRQ : ST_IDLE;
          end else begin
            unit_q <= unit_q + 1'b1;
          end
        end
        ST_BIT: begin
          if (!cur_vec[bit_q] || wr_ready_i) begin
            if (last_bit) state_q <= ST_SRC;
            else          bit_q   <= bit_q + 1'b1;
          end
        end
        ST_SRC: begin
          if (wr_ready_i) begin
            if (last_unit) begin
              state_q <= ST_IRQ;
            end else begin
              unit_q  <= unit_q + 1'b1;
              state_q <= ST_UNIT;
            end
          end
        end
        ST_IRQ:  state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    rd_req_o   = (state_q == ST_FETCH);
    take_o     = rd_req_o && rd_valid_i;
    sel_src_o  = (state_q == ST_SRC);
    wr_valid_o = ((state_q == ST_BIT) && cur_vec[bit_q]) || sel_src_o;
    host_irq_o = (state_q == ST_IRQ);
  end

  assign unit_o = unit_q;
  assign bit_o  = bit_q;
endmodule

// File: rtl/mbi_report_writer.sv
module mbi_report_writer
  import mbi_pkg::*;
#(
  parameter int                NUM_UNITS = 6,
  parameter int                ADDR_W    = 32,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 'h1000
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [NUM_UNITS*VEC_W-1:0] evt_i,
  output logic                       wr_valid_o,
  input  logic                       wr_ready_i,
  output logic [ADDR_W-1:0]          wr_addr_o,
  output logic [7:0]                 wr_data_o,
  output logic                       rd_req_o,
  output logic [ADDR_W-1:0]          rd_addr_o,
  input  logic                       rd_valid_i,
  input  logic [VEC_W-1:0]           rd_data_i,
  output logic                       host_irq_o
);
  localparam int UNIT_W = (NUM_UNITS > 1) ? $clog2(NUM_UNITS) : 1;
  localparam int BIT_W  = $clog2(VEC_W);

  logic [NUM_UNITS*VEC_W-1:0] snap;
  logic                       pend_any;
  logic                       take;
  logic                       sel_src;
  logic [UNIT_W-1:0]          unit_idx;
  logic [BIT_W-1:0]           bit_idx;

  mbi_pending #(.NUM_UNITS(NUM_UNITS)) u_pending (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .evt_i     (evt_i),
    .take_i    (take),
    .mask_i    (rd_data_i),
    .snap_o    (snap),
    .pend_any_o(pend_any)
  );

  mbi_seq #(.NUM_UNITS(NUM_UNITS)) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .pend_any_i(pend_any),
    .snap_i    (snap),
    .rd_valid_i(rd_valid_i),
    .wr_ready_i(wr_ready_i),
    .take_o    (take),
    .rd_req_o  (rd_req_o),
    .wr_valid_o(wr_valid_o),
    .sel_src_o (sel_src),
    .unit_o    (unit_idx),
    .bit_o     (bit_idx),
    .host_irq_o(host_irq_o)
  );

  mbi_addr_gen #(
    .NUM_UNITS(NUM_UNITS),
    .ADDR_W   (ADDR_W),
    .BASE_ADDR(BASE_ADDR)
  ) u_addr (
    .unit_i   (unit_idx),
    .bit_i    (bit_idx),
    .sel_src_i(sel_src),
    .wr_addr_o(wr_addr_o),
    .rd_addr_o(rd_addr_o)
  );

  assign wr_data_o = MARK;
endmodule

// File: rtl/mbi_report_writer_chk.sv
module mbi_report_writer_chk
  import mbi_pkg::*;
#(
  parameter int                NUM_UNITS = 6,
  parameter int                ADDR_W    = 32,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 'h1000
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_valid_o,
  input logic              wr_ready_i,
  input logic [ADDR_W-1:0] wr_addr_o,
  input logic              rd_req_o,
  input logic              rd_valid_i,
  input logic [VEC_W-1:0]  rd_data_i,
  input logic              host_irq_o
);
  logic [VEC_W-1:0]  mask_q;
  logic [ADDR_W-1:0] off;
  logic              in_stat;
  logic              in_src;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      mask_q <= '0;
    else if (rd_req_o && rd_valid_i)  mask_q <= rd_data_i;
  end

  assign off     = wr_addr_o - BASE_ADDR;
  assign in_stat = (wr_addr_o >= BASE_ADDR) && (off < ADDR_W'(NUM_UNITS * STAT_STRIDE));
  assign in_src  = (wr_addr_o >= BASE_ADDR) && (off >= ADDR_W'(SRC_OFS)) &&
                   (off < ADDR_W'(SRC_OFS + NUM_UNITS));

  assert_wr_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_o && !wr_ready_i |=> wr_valid_o && $stable(wr_addr_o));

  assert_irq_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_irq_o |=> !host_irq_o);

  assert_irq_quiet_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_irq_o |-> !wr_valid_o && !rd_req_o);

  assert_wr_window_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_o |-> in_stat || in_src);

  assert_mask_gate_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_o && in_stat |-> mask_q[off[3:0]]);

  assert_rd_excl_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o |-> !wr_valid_o);
endmodule

bind mbi_report_writer mbi_report_writer_chk #(
  .NUM_UNITS(NUM_UNITS),
  .ADDR_W   (ADDR_W),
  .BASE_ADDR(BASE_ADDR)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wr_valid_o(wr_valid_o),
  .wr_ready_i(wr_ready_i),
  .wr_addr_o (wr_addr_o),
  .rd_req_o  (rd_req_o),
  .rd_valid_i(rd_valid_i),
  .rd_data_i (rd_data_i),
  .host_irq_o(host_irq_o)
);

// File: tb/mbi_report_writer_test.sv
module mbi_report_writer_test;
  localparam int CLK_PERIOD = 10;
  localparam int NU   = 6;
  localparam int AW   = 32;
  localparam logic [AW-1:0] BASE = 32'h0000_1000;
  localparam int MAXL = 1024;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NU*16-1:0] evt = '0;
  logic            wr_valid, wr_ready = 1'b0;
  logic [AW-1:0]   wr_addr;
  logic [7:0]      wr_data;
  logic            rd_req, rd_valid = 1'b0;
  logic [AW-1:0]   rd_addr;
  logic [15:0]     rd_data = '0;
  logic            host_irq;

  logic [15:0]   mask_cfg = 16'hFFFF;
  logic [AW-1:0] log_a [MAXL];
  logic [7:0]    log_d [MAXL];
  int            log_n = 0;
  logic [AW-1:0] exp_a [MAXL];
  int            exp_n = 0;
  int            irq_cnt = 0;
  int            irq_at [8];
  int            rd_cnt = 0;
  int            rd_bad = 0;
  int            n_chk = 0, n_fail = 0;
  int            cyc = 0;
  bit            done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mbi_report_writer #(.NUM_UNITS(NU), .ADDR_W(AW), .BASE_ADDR(BASE)) uut (
    .clk_i(clk), .rst_ni(rst_n), .evt_i(evt),
    .wr_valid_o(wr_valid), .wr_ready_i(wr_ready), .wr_addr_o(wr_addr), .wr_data_o(wr_data),
    .rd_req_o(rd_req), .rd_addr_o(rd_addr), .rd_valid_i(rd_valid), .rd_data_i(rd_data),
    .host_irq_o(host_irq)
  );

  // memory responder and monitor: drive at negedge, then record what the next edge accepts
  always @(negedge clk) begin
    wr_ready = ($urandom % 2) == 0;
    rd_valid = rd_req && (($urandom % 3) == 0);
    rd_data  = mask_cfg;
    #1;
    if (wr_valid && wr_ready && log_n < MAXL) begin
      log_a[log_n] = wr_addr;
      log_d[log_n] = wr_data;
      log_n++;
    end
    if (rd_req && rd_valid) begin
      rd_cnt++;
      if (rd_addr != BASE + 32'h440) rd_bad++;
    end
    if (host_irq) begin
      if (irq_cnt < 8) irq_at[irq_cnt] = log_n;
      irq_cnt++;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic clear_obs();
    log_n = 0; exp_n = 0; irq_cnt = 0; rd_cnt = 0; rd_bad = 0;
  endtask

  // expected write list of one pass
  task automatic add_pass(input logic [NU*16-1:0] v, input logic [15:0] m);
    for (int u = 0; u < NU; u++) begin
      logic [15:0] mv;
      mv = v[u*16 +: 16] & m;
      for (int b = 0; b < 16; b++)
        if (mv[b]) begin exp_a[exp_n] = BASE + AW'(u*16 + b); exp_n++; end
      if (mv != 0) begin exp_a[exp_n] = BASE + 32'h400 + AW'(u); exp_n++; end
    end
  endtask

  task automatic fire(input logic [NU*16-1:0] v);
    @(negedge clk); evt = v;
    @(negedge clk); evt = '0;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic compare(input int exp_irq, input int exp_rd);
    chk(log_n == exp_n, "R3 write count", log_n, exp_n);
    for (int i = 0; i < exp_n && i < log_n; i++) begin
      chk(log_a[i] == exp_a[i], (exp_a[i] - BASE >= 32'h400) ? "R2 source addr" : "R1 status addr",
          int'(log_a[i]), int'(exp_a[i]));
      chk(log_d[i] == 8'hFF, "R1 marker byte", int'(log_d[i]), 8'hFF);
    end
    chk(irq_cnt == exp_irq, "R6 irq count", irq_cnt, exp_irq);
    chk(rd_cnt == exp_rd, "R4 mask reads", rd_cnt, exp_rd);
    chk(rd_bad == 0, "R4 mask addr", rd_bad, 0);
  endtask

  task automatic one_pass(input logic [NU*16-1:0] v, input logic [15:0] m);
    logic [NU*16-1:0] mm;
    mm = '0;
    for (int u = 0; u < NU; u++) mm[u*16 +: 16] = m;
    clear_obs();
    mask_cfg = m;
    add_pass(v, m);
    fire(v);
    wait_cyc(700);
    compare(((v & mm) != 0) ? 1 : 0, (v != 0) ? 1 : 0);
    if ((v & mm) != 0) chk(irq_at[0] == exp_n, "R6 irq after writes", irq_at[0], exp_n);
  endtask

  initial begin
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
      end
    end
  end

  initial begin
    logic [NU*16-1:0] v;
    logic [NU*16-1:0] va, vb;
    int len1;
    wait_cyc(3);
    chk(!wr_valid && !rd_req && !host_irq, "R9 reset outputs",
        {wr_valid, rd_req, host_irq}, 0);
    @(negedge clk); rst_n = 1'b1;
    wait_cyc(3);
    chk(!wr_valid && !rd_req && !host_irq, "R9 idle after reset",
        {wr_valid, rd_req, host_irq}, 0);

    // single bit on unit 0, then full vector on the last unit
    v = '0; v[0] = 1'b1;
    one_pass(v, 16'hFFFF);
    v = '0; v[(NU-1)*16 +: 16] = 16'hFFFF;
    one_pass(v, 16'hFFFF);

    // R5: all masked, nothing written, and the masked events are discarded
    v = '0; v[0 +: 16] = 16'h00F0; v[3*16 +: 16] = 16'h8001;
    one_pass(v, 16'h0000);
    v = '0; v[1*16 + 2] = 1'b1;
    one_pass(v, 16'hFFFF);

    // R4: new mask value takes effect on the next pass
    v = '0; v[2*16 +: 16] = 16'hFFFF;
    one_pass(v, 16'h00FF);
    one_pass(v, 16'hFF00);

    // R7: events during a pass are reported in a following pass
    clear_obs();
    mask_cfg = 16'hFFFF;
    va = '0; va[1*16 +: 16] = 16'h0C03;
    vb = '0; vb[1*16 +: 16] = 16'h0030; vb[2*16 +: 16] = 16'h4000;
    add_pass(va, 16'hFFFF);
    len1 = exp_n;
    add_pass(vb, 16'hFFFF);
    fire(va);
    while (log_n == 0) @(negedge clk);
    fire(vb);
    wait_cyc(1500);
    compare(2, 2);
    chk(irq_at[0] == len1, "R7 first pass irq", irq_at[0], len1);
    chk(irq_at[1] == exp_n, "R7 second pass irq", irq_at[1], exp_n);

    // random passes
    void'($urandom(32'h5eed_1234));
    for (int t = 0; t < 24; t++) begin
      logic [15:0] m;
      v = '0;
      for (int u = 0; u < NU; u++)
        if (($urandom % 2) == 0) v[u*16 +: 16] = 16'($urandom);
      case ($urandom % 4)
        0:       m = 16'hFFFF;
        1:       m = 16'h0000;
        default: m = 16'($urandom);
      endcase
      one_pass(v, m);
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule